// File: doc/BRIEF.md
# Per-Port Repeater Statistics Engine

This block keeps the management statistics of a single repeater port. A frame monitor upstream hands it one-cycle pulses: an end-of-frame strobe carrying the frame's byte length and its destination class (broadcast or multicast), and an 8-bit vector of event pulses for checksum errors, alignment errors, overlong frames, short events, runts, collisions, jabber and dropped frames. From these it maintains free-running 32-bit counters, a six-bin frame-length histogram and a combined checksum-plus-alignment error count. It also presents several counters a second time at their own addresses, where two statistics lists define the same quantity.

A second set of history counters accumulates the same kinds of traffic, but only inside a sampling window. The window is measured in one-second ticks. Its length comes from a 16-bit period register, which the sampling state machine loads when software sets the sample-enable bit. The bit clears itself when the window closes. A host reads any counter through a 16-bit read port, as a low half and a high half. Reading the low half captures the high half, so the two reads form one consistent 32-bit value.

Top module: `port_stats_engine`

## Requirements
- R1: After synchronous reset every counter reads 0, `sample_active` is 0, and a high-half read made before any low-half read returns 0.
- R2: `rd_addr[6:1]` selects a counter index and `rd_addr[0]` selects the half (0 = bits 15:0, 1 = bits 31:16). `rd_data` is registered and valid in the cycle after `rd_en`. A high-half read returns the upper 16 bits captured by the most recent low-half read of any index, even if the counter has changed since then.
- R3: Each `frame_end` pulse adds 1 to frames (index 0) and adds `frame_len` to octets (index 1), frames of any length included.
- R4: Each `frame_end` adds 1 to exactly one histogram bin when the length falls inside it: index 13 for exactly 64 bytes, 14 for 65-127, 15 for 128-255, 16 for 256-511, 17 for 512-1023 and 18 for 1024-1518. A length below 64 or above 1518 touches no bin.
- R5: The checksum/alignment count (index 12) always equals the checksum-error count (index 2) plus the alignment-error count (index 3). When both pulses arrive in the same cycle it rises by 2.
- R6: The alias indices return the same value as their base counter: 19 = octets, 20 = frames, 21 = short events, 22 = too-long frames, 23 = runts.
- R7: Each `evt_pulse` bit adds 1 to its own counter: bit0 checksum (2), bit1 alignment (3), bit2 too long (4), bit3 short event (5), bit4 runt (6), bit5 collision (7), bit6 jabber (8), bit7 drop (9). `dst_bcast` and `dst_mcast` add 1 to broadcast (10) and multicast (11) only together with `frame_end`; without it they change nothing.
- R8: A `sample_go` while idle loads the period value N (written earlier by `period_wr`) and raises `sample_active`. `sample_active` falls right after the (N+1)-th `tick_1s`.
- R9: History counters (indices 32-42: drop, octets, frames, broadcast, multicast, checksum/alignment, undersize, oversize, fragments, jabber, collision) clear when a window starts, count the same events as their statistics counterparts only while `sample_active` is 1, and hold their values once the window ends, until the next start.
- R10: A `sample_go` during a running window has no effect. A `period_wr` during a window does not change that window and applies at the next start.
- R11: Unmapped indices (24-31, 43-63) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| frame_end | input | 1 | End-of-frame strobe |
| frame_len | input | 11 | Byte length of the ending frame |
| dst_bcast | input | 1 | Ending frame has a broadcast destination |
| dst_mcast | input | 1 | Ending frame has a multicast destination |
| evt_pulse | input | 8 | Per-event pulses, bit map in R7 |
| period_wr | input | 1 | Write strobe for the sample period |
| period_val | input | 16 | Sample period value N (window of N+1 s) |
| sample_go | input | 1 | Set the sample-enable bit |
| sample_active | output | 1 | Sample-enable bit, cleared by hardware at window end |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Counter index and half select |
| rd_data | output | 16 | Registered read data |

## Verification
Assertions check on every cycle that the checksum/alignment count stays the sum of its two sources, that frames rise by exactly one per end-of-frame strobe and never otherwise, that no frame hits two histogram bins, that the window ends only on a tick, that a running window ignores a second start, and that history counters stay frozen outside a window. The exact bin edges, the alias addresses, the N+1 tick window length, a period change that only applies at the next start, and the high-half capture that tears apart from a live counter can only be shown by the bench. It sweeps lengths across every bin edge, all 256 event-pulse combinations and several window runs, and compares reads with values it computes itself.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

    localparam int HALF_W   = 16;
    localparam int CNT_W    = 2 * HALF_W;
    localparam int LEN_W    = 11;
    localparam int PER_W    = 16;
    localparam int EVT_W    = 8;
    localparam int IDX_W    = 6;
    localparam int ADDR_W   = IDX_W + 1;
    localparam int NBIN     = 6;
    localparam int NSTAT    = 13 + NBIN;
    localparam int NHIST    = 11;
    localparam int HIST_BASE = 32;

    // statistics counter slots
    localparam int S_FRAMES = 0;
    localparam int S_OCTETS = 1;
    localparam int S_FCS    = 2;
    localparam int S_ALIGN  = 3;
    localparam int S_LONG   = 4;
    localparam int S_SHORT  = 5;
    localparam int S_RUNT   = 6;
    localparam int S_COLL   = 7;
    localparam int S_JABBER = 8;
    localparam int S_DROP   = 9;
    localparam int S_BCAST  = 10;
    localparam int S_MCAST  = 11;
    localparam int S_CRCAL  = 12;
    localparam int S_BIN0   = 13;

    // alias read indices
    localparam int A_OCTETS = 19;
    localparam int A_FRAMES = 20;
    localparam int A_UNDER  = 21;
    localparam int A_OVER   = 22;
    localparam int A_FRAG   = 23;

    // history counter slots (read index = HIST_BASE + slot)
    localparam int H_DROP   = 0;
    localparam int H_OCTETS = 1;
    localparam int H_FRAMES = 2;
    localparam int H_BCAST  = 3;
    localparam int H_MCAST  = 4;
    localparam int H_CRCAL  = 5;
    localparam int H_UNDER  = 6;
    localparam int H_OVER   = 7;
    localparam int H_FRAG   = 8;
    localparam int H_JABBER = 9;
    localparam int H_COLL   = 10;

    // event pulse vector, bit0 = fcs ... bit7 = drop
    typedef struct packed {
        logic drop;
        logic jabber;
        logic coll;
        logic runt;
        logic short_ev;
        logic too_long;
        logic align;
        logic fcs;
    } evt_t;

    typedef enum logic {WIN_IDLE, WIN_RUN} win_state_e;

    typedef logic [NSTAT-1:0][CNT_W-1:0] stat_vec_t;
    typedef logic [NHIST-1:0][CNT_W-1:0] hist_vec_t;

    function automatic logic [LEN_W-1:0] bin_lo(input int b);
        if (b == 0) return LEN_W'(64);
        if (b == 1) return LEN_W'(65);
        return LEN_W'(32 << b);
    endfunction

    function automatic logic [LEN_W-1:0] bin_hi(input int b);
        if (b == 0) return LEN_W'(64);
        if (b == NBIN - 1) return LEN_W'(1518);
        return LEN_W'((64 << b) - 1);
    endfunction

endpackage

// File: rtl/pstat_event_decode.sv
module pstat_event_decode
    import pstat_pkg::*;
(
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             dst_bcast,
    input  logic             dst_mcast,
    input  evt_t             evt,
    output stat_vec_t        stat_inc,
    output hist_vec_t        hist_inc
);

    logic [NBIN-1:0] hits;

    always_comb begin
        hits = '0;
        for (int b = 0; b < NBIN; b++) begin
            if (frame_end && frame_len >= bin_lo(b) && frame_len <= bin_hi(b))
                hits[b] = 1'b1;
        end
    end

    // R4
    always_comb begin
        if (!$isunknown(hits))
            r4_bin_onehot_chk: assert ($onehot0(hits));
    end

    always_comb begin
        stat_inc           = '0;
        stat_inc[S_FRAMES] = CNT_W'(frame_end);
        stat_inc[S_OCTETS] = frame_end ? CNT_W'(frame_len) : '0;
        stat_inc[S_FCS]    = CNT_W'(evt.fcs);
        stat_inc[S_ALIGN]  = CNT_W'(evt.align);
        stat_inc[S_LONG]   = CNT_W'(evt.too_long);
        stat_inc[S_SHORT]  = CNT_W'(evt.short_ev);
        stat_inc[S_RUNT]   = CNT_W'(evt.runt);
        stat_inc[S_COLL]   = CNT_W'(evt.coll);
        stat_inc[S_JABBER] = CNT_W'(evt.jabber);
        stat_inc[S_DROP]   = CNT_W'(evt.drop);
        stat_inc[S_BCAST]  = CNT_W'(frame_end & dst_bcast);
        stat_inc[S_MCAST]  = CNT_W'(frame_end & dst_mcast);
        stat_inc[S_CRCAL]  = CNT_W'(evt.fcs) + CNT_W'(evt.align);
        for (int b = 0; b < NBIN; b++)
            stat_inc[S_BIN0 + b] = CNT_W'(hits[b]);
    end

    always_comb begin
        hist_inc           = '0;
        hist_inc[H_DROP]   = stat_inc[S_DROP];
        hist_inc[H_OCTETS] = stat_inc[S_OCTETS];
        hist_inc[H_FRAMES] = stat_inc[S_FRAMES];
        hist_inc[H_BCAST]  = stat_inc[S_BCAST];
        hist_inc[H_MCAST]  = stat_inc[S_MCAST];
        hist_inc[H_CRCAL]  = stat_inc[S_CRCAL];
        hist_inc[H_UNDER]  = stat_inc[S_SHORT];
        hist_inc[H_OVER]   = stat_inc[S_LONG];
        hist_inc[H_FRAG]   = stat_inc[S_RUNT];
        hist_inc[H_JABBER] = stat_inc[S_JABBER];
        hist_inc[H_COLL]   = stat_inc[S_COLL];
    end

endmodule

// File: rtl/pstat_counter_bank.sv
module pstat_counter_bank #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic [N-1:0][W-1:0] inc,
    output logic [N-1:0][W-1:0] cnt
);

    for (genvar i = 0; i < N; i++) begin : g_cnt
        logic [W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst || clr)
                r <= '0;
            else if (en)
                r <= r + inc[i];
        end
        assign cnt[i] = r;
    end

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/pstat_window.sv
module pstat_window
    import pstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             go,
    input  logic             period_wr,
    input  logic [PER_W-1:0] period_in,
    output logic             active,
    output logic             start
);

    win_state_e       state;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] rem;

    assign active = (state == WIN_RUN);
    assign start  = go && (state == WIN_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WIN_IDLE;
            period_q <= '0;
            rem      <= '0;
        end else begin
            if (period_wr)
                period_q <= period_in;
            case (state)
                WIN_IDLE: begin
                    if (go) begin
                        state <= WIN_RUN;
                        rem   <= period_q;
                    end
                end
                WIN_RUN: begin
                    if (tick) begin
                        if (rem == '0)
                            state <= WIN_IDLE;
                        else
                            rem <= rem - 1'b1;
                    end
                end
                default: state <= WIN_IDLE;
            endcase
        end
    end

    // R8
    win_end_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(tick));

    // R8
    win_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> active && rem == $past(period_q));

    // R10
    win_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> active && $stable(rem));

endmodule

// File: rtl/port_stats_engine.sv
module port_stats_engine
    import pstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1s,
    input  logic              frame_end,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              dst_bcast,
    input  logic              dst_mcast,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic              period_wr,
    input  logic [PER_W-1:0]  period_val,
    input  logic              sample_go,
    output logic              sample_active,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_data
);

    stat_vec_t         stat_inc;
    hist_vec_t         hist_inc;
    stat_vec_t         stat_cnt;
    hist_vec_t         hist_cnt;
    logic              win_start;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  sel_val;
    logic [HALF_W-1:0] hi_hold;

    pstat_event_decode u_decode (
        .frame_end (frame_end),
        .frame_len (frame_len),
        .dst_bcast (dst_bcast),
        .dst_mcast (dst_mcast),
        .evt       (evt_t'(evt_pulse)),
        .stat_inc  (stat_inc),
        .hist_inc  (hist_inc)
    );

    pstat_counter_bank #(.N(NSTAT), .W(CNT_W)) u_stats (
        .clk (clk),
        .rst (rst),
        .clr (1'b0),
        .en  (1'b1),
        .inc (stat_inc),
        .cnt (stat_cnt)
    );

    pstat_window u_window (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_1s),
        .go        (sample_go),
        .period_wr (period_wr),
        .period_in (period_val),
        .active    (sample_active),
        .start     (win_start)
    );

    pstat_counter_bank #(.N(NHIST), .W(CNT_W)) u_hist (
        .clk (clk),
        .rst (rst),
        .clr (win_start),
        .en  (sample_active),
        .inc (hist_inc),
        .cnt (hist_cnt)
    );

    assign rd_idx = rd_addr[ADDR_W-1:1];

    always_comb begin
        sel_val = '0;
        if (int'(rd_idx) < NSTAT)
            sel_val = stat_cnt[rd_idx];
        else if (int'(rd_idx) >= HIST_BASE && int'(rd_idx) < HIST_BASE + NHIST)
            sel_val = hist_cnt[int'(rd_idx) - HIST_BASE];
        else begin
            case (int'(rd_idx))
                A_OCTETS: sel_val = stat_cnt[S_OCTETS];
                A_FRAMES: sel_val = stat_cnt[S_FRAMES];
                A_UNDER:  sel_val = stat_cnt[S_SHORT];
                A_OVER:   sel_val = stat_cnt[S_LONG];
                A_FRAG:   sel_val = stat_cnt[S_RUNT];
                default:  sel_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            hi_hold <= '0;
        end else if (rd_en) begin
            if (!rd_addr[0]) begin
                rd_data <= sel_val[HALF_W-1:0];
                hi_hold <= sel_val[CNT_W-1:HALF_W];
            end else begin
                rd_data <= hi_hold;
            end
        end
    end

    // R5
    crcal_sum_chk: assert property (@(posedge clk) disable iff (rst)
        stat_cnt[S_CRCAL] == stat_cnt[S_FCS] + stat_cnt[S_ALIGN]);

    // R3
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> stat_cnt[S_FRAMES] == $past(stat_cnt[S_FRAMES]) + 1);

    // R3
    frame_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(stat_cnt[S_FRAMES]));

    // R9
    hist_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_active && !win_start) |=> $stable(hist_cnt));

endmodule

// File: tb/port_stats_engine_tb.sv
module port_stats_engine_tb_top;

    logic        clk = 0;
    logic        rst = 1;
    logic        tick_1s = 0;
    logic        frame_end = 0;
    logic [10:0] frame_len = 0;
    logic        dst_bcast = 0;
    logic        dst_mcast = 0;
    logic [7:0]  evt_pulse = 0;
    logic        period_wr = 0;
    logic [15:0] period_val = 0;
    logic        sample_go = 0;
    logic        sample_active;
    logic        rd_en = 0;
    logic [6:0]  rd_addr = 0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] e_stat [0:18];
    logic [31:0] e_hist [0:10];
    logic        win_on = 0;
    int          win_left = 0;
    int          e_period = 0;

    always #5 clk = ~clk;

    port_stats_engine dut_i (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .frame_end(frame_end),
        .frame_len(frame_len), .dst_bcast(dst_bcast), .dst_mcast(dst_mcast),
        .evt_pulse(evt_pulse), .period_wr(period_wr), .period_val(period_val),
        .sample_go(sample_go), .sample_active(sample_active),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_of(input int idx);
        if (idx <= 18) return e_stat[idx];
        if (idx == 19) return e_stat[1];
        if (idx == 20) return e_stat[0];
        if (idx == 21) return e_stat[5];
        if (idx == 22) return e_stat[4];
        if (idx == 23) return e_stat[6];
        if (idx >= 32 && idx <= 42) return e_hist[idx-32];
        return 32'h0;
    endfunction

    function automatic int bin_of(input int len);
        if (len == 64) return 13;
        if (len >= 65 && len <= 127) return 14;
        if (len >= 128 && len <= 255) return 15;
        if (len >= 256 && len <= 511) return 16;
        if (len >= 512 && len <= 1023) return 17;
        if (len >= 1024 && len <= 1518) return 18;
        return -1;
    endfunction

    task automatic rd_half(input int idx, input bit hi, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1; rd_addr = {idx[5:0], hi};
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    task automatic check_idx(input string tag, input int idx);
        logic [15:0] lo, hi;
        rd_half(idx, 0, lo);
        rd_half(idx, 1, hi);
        check($sformatf("%s idx %0d", tag, idx), {hi, lo}, exp_of(idx));
    endtask

    task automatic send_frame(input int len, input bit bc, input bit mc);
        int b;
        @(negedge clk);
        frame_end = 1; frame_len = 11'(len); dst_bcast = bc; dst_mcast = mc;
        @(negedge clk);
        frame_end = 0; dst_bcast = 0; dst_mcast = 0;
        b = bin_of(len);
        e_stat[0] += 1; e_stat[1] += 32'(len);
        if (bc) e_stat[10] += 1;
        if (mc) e_stat[11] += 1;
        if (b >= 0) e_stat[b] += 1;
        if (win_on) begin
            e_hist[2] += 1; e_hist[1] += 32'(len);
            if (bc) e_hist[3] += 1;
            if (mc) e_hist[4] += 1;
        end
    endtask

    task automatic send_evt(input logic [7:0] m);
        @(negedge clk);
        evt_pulse = m;
        @(negedge clk);
        evt_pulse = 0;
        for (int i = 0; i < 8; i++) if (m[i]) e_stat[2+i] += 1;
        e_stat[12] += 32'(m[0]) + 32'(m[1]);
        if (win_on) begin
            e_hist[0]  += 32'(m[7]);
            e_hist[5]  += 32'(m[0]) + 32'(m[1]);
            e_hist[6]  += 32'(m[3]);
            e_hist[7]  += 32'(m[2]);
            e_hist[8]  += 32'(m[4]);
            e_hist[9]  += 32'(m[6]);
            e_hist[10] += 32'(m[5]);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        tick_1s = 1;
        @(negedge clk);
        tick_1s = 0;
        if (win_on) begin
            if (win_left == 0) win_on = 0;
            else win_left--;
        end
        check(tag, 32'(sample_active), 32'(win_on));
    endtask

    task automatic write_period(input int p);
        @(negedge clk);
        period_wr = 1; period_val = 16'(p);
        @(negedge clk);
        period_wr = 0;
        e_period = p;
    endtask

    task automatic go();
        @(negedge clk);
        sample_go = 1;
        @(negedge clk);
        sample_go = 0;
        if (!win_on) begin
            win_on = 1; win_left = e_period;
            for (int i = 0; i < 11; i++) e_hist[i] = 0;
        end
    endtask

    function automatic int sweep_len(input int i);
        case (i)
            0: return 0;     1: return 1;     2: return 63;    3: return 64;
            4: return 65;    5: return 100;   6: return 127;   7: return 128;
            8: return 255;   9: return 256;   10: return 511;  11: return 512;
            12: return 1023; 13: return 1024; 14: return 1517; 15: return 1518;
            16: return 1519; default: return 2047;
        endcase
    endfunction

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v, lo0, hi0;
        logic [31:0] snap;
        for (int i = 0; i < 19; i++) e_stat[i] = 0;
        for (int i = 0; i < 11; i++) e_hist[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 active after reset", 32'(sample_active), 0);
        rd_half(5, 1, v);
        check("R1 hi before lo", 32'(v), 0);
        foreach (e_stat[i]) check_idx("R1", i);
        check_idx("R1", 32);

        // R3 R4 R7 length sweep over every bin edge
        for (int i = 0; i < 18; i++)
            send_frame(sweep_len(i), (i % 3) == 0, (i % 3) == 1);
        for (int i = 0; i < 19; i++) check_idx("R3 R4 R7 sweep", i);
        // R6 aliases
        for (int i = 19; i < 24; i++) check_idx("R6 alias", i);

        // R5 R7 all event pulse combinations
        for (int m = 0; m < 256; m++) send_evt(8'(m));
        for (int i = 2; i < 10; i++) check_idx("R7 events", i);
        check_idx("R5 crc+align", 12);
        for (int i = 21; i < 24; i++) check_idx("R6 alias", i);

        // R7 destination class without frame_end is ignored
        @(negedge clk); dst_bcast = 1; dst_mcast = 1;
        @(negedge clk); dst_bcast = 0; dst_mcast = 0;
        check_idx("R7 bcast no frame", 10);
        check_idx("R7 mcast no frame", 11);

        // R11 unmapped
        check_idx("R11", 24); check_idx("R11", 31); check_idx("R11", 43); check_idx("R11", 63);

        // R8 R9 window of period 3 -> 4 ticks
        write_period(3);
        go();
        check("R8 active at start", 32'(sample_active), 1);
        for (int i = 32; i < 43; i++) check_idx("R9 cleared", i);
        send_frame(64, 1, 0);
        send_evt(8'hFF);
        tick("R8 tick1");
        write_period(1);                      // R10 mid-window write
        go();                                 // R10 ignored restart
        for (int i = 32; i < 43; i++) check_idx("R10 no restart", i);
        send_frame(700, 0, 1);
        tick("R8 tick2");
        send_evt(8'h23);
        tick("R8 tick3");
        send_frame(1518, 1, 1);
        tick("R8 tick4 end");
        for (int i = 32; i < 43; i++) check_idx("R9 window", i);
        // R9 hold after window
        send_frame(300, 1, 1);
        send_evt(8'hFF);
        for (int i = 32; i < 43; i++) check_idx("R9 hold", i);

        // R10 new period applies at next start: 2 ticks
        go();
        for (int i = 32; i < 43; i++) check_idx("R9 restart clear", i);
        send_frame(128, 0, 0);
        tick("R10 tick1");
        tick("R10 tick2 end");
        tick("R10 idle tick");
        check_idx("R9 short window", 33);
        check_idx("R9 short window", 34);

        // R2 high half captured by low read
        while (e_stat[1][15:0] < 16'd60000) send_frame(1518, 0, 0);
        rd_half(1, 0, lo0);
        check("R2 lo", 32'(lo0), 32'(e_stat[1][15:0]));
        snap = e_stat[1];
        while (e_stat[1][31:16] == snap[31:16]) send_frame(1518, 0, 0);
        rd_half(1, 1, hi0);
        check("R2 hi captured", 32'(hi0), 32'(snap[31:16]));
        check_idx("R2 fresh pair", 1);
        check_idx("R2 fresh pair", 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule